// File: doc/BRIEF.md
# Clock Lane High-Speed Entry/Exit Sequencer

This block runs the clock lane of a serial display transmitter physical layer. It sits in the stop state, with both low-power lines high, until the link layer asks for a high-speed clock. It then walks the lane through the low-power and high-speed phases the protocol requires before the continuous clock can run. When the request is withdrawn, it walks the lane back to stop. Every phase lasts a number of lane byte clock cycles taken from a programmed timing field. One byte clock equals eight high-speed bit periods, and the whole block runs on the byte clock.

The clock-side timing word carries four 8-bit counts, and a second word carries the pre-time count in its low byte. The post count is meant to cover the clock post time plus the data-lane trail time, so that one field sets the entire wait after data ends. A clock-ready flag tells the data lanes when the clock has run long enough to be stable. Each of the two lane-enable outputs can be taken from a register bit instead of the state machine. A power-down input, which also powers down the whole physical layer, idles the lane at once. A 4-bit status word reports analog-ready, stop, ultra-low-power and high-speed-active.

Top module: `clk_lane_seq`

## Requirements
- R1: After reset, the lane is in stop. `tx_lp_en_o`=1, `tx_hs_en_o`=0, `lp_line_o`=2'b11 (bit 1 = positive line, bit 0 = negative line), and `clk_run_o`=0 and `clk_ready_o`=0.
- R2: When `hs_req_i` is sampled high in stop and analog is ready, entry proceeds in this order:
  - LP-01 (`lp_line_o`=2'b01, `tx_lp_en_o`=1) for the `tlpx_i` count;
  - LP-00 (`lp_line_o`=2'b00, `tx_lp_en_o`=1) for the prepare count;
  - HS-0 (`tx_hs_en_o`=1, `tx_lp_en_o`=0, `clk_run_o`=0) for the zero count;
  - the running clock (`clk_run_o`=1).
  The two enables are never both high from the state machine.
- R3: The timing word `clk_tim_i` holds four fields: prepare in bits 31:24, zero in 23:16, post in 15:8 and trail in 7:0.
- R4: A timing count of zero lasts one byte-clock cycle. Any other count N lasts exactly N cycles.
- R5: `clk_ready_o` goes high after the clock has run for the pre count, taken from bits 7:0 of `pre_tim_i`, whose upper bits have no effect. It is high only while the clock runs and the request is still present.
- R6: When `hs_req_i` is sampled low while the clock runs, the clock keeps running for the post count. The lane then drives HS-0 for the trail count and returns to stop.
- R7: A request raised during exit does not shorten post or trail. The lane stays in stop for exactly one cycle and then begins a new entry.
- R8: While `ana_ready_i` is low, a request leaves the lane in stop.
- R9: `status_o` is {`ana_ready_i`, in stop, ultra-low-power (always 0), state-machine high-speed enable}, most significant bit first.
- R10: When `hs_sel_i`/`lp_sel_i` is 1, `tx_hs_en_o`/`tx_lp_en_o` follows `hs_val_i`/`lp_val_i` in the same cycle. The state machine and status are unaffected.
- R11: `pwr_down_i` forces both enables, `clk_run_o` and `clk_ready_o` low in the same cycle, overriding the select bits. The lane returns to stop on the next edge and ignores requests while power-down is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hs_req_i | input | 1 | High-speed clock request from the link layer |
| ana_ready_i | input | 1 | Analog front end powered and ready |
| pwr_down_i | input | 1 | Lane and PHY power-down |
| clk_tim_i | input | 32 | Prepare/zero/post/trail counts |
| pre_tim_i | input | 32 | Pre count in bits 7:0; upper bits reserved |
| tlpx_i | input | 8 | LP-01 duration count |
| hs_sel_i | input | 1 | Take `tx_hs_en_o` from `hs_val_i` |
| hs_val_i | input | 1 | Register value for the high-speed enable |
| lp_sel_i | input | 1 | Take `tx_lp_en_o` from `lp_val_i` |
| lp_val_i | input | 1 | Register value for the low-power enable |
| tx_lp_en_o | output | 1 | Low-power driver enable |
| tx_hs_en_o | output | 1 | High-speed driver enable |
| lp_line_o | output | 2 | Low-power line state {positive, negative} |
| clk_run_o | output | 1 | High-speed clock toggling |
| clk_ready_o | output | 1 | Clock stable; data lanes may start |
| status_o | output | 4 | {analog ready, stop, ultra-low-power, high-speed active} |

## Verification
A phase counter that loads the wrong field, or is off by one, shows up at the ports as a phase of the wrong length. The bench therefore measures every phase in cycles from the line state and the enables, for each burst, against lengths it computes itself. A wrong state transition appears within one cycle as an illegal line or enable pattern, or as a status word that does not match the phase. A stale pre counter shows up as `clk_ready_o` rising early or late within the first running cycles. A missed power-down appears on the enables in the same cycle.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;
  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_LPX   = 3'd1,
    ST_PREP  = 3'd2,
    ST_ZERO  = 3'd3,
    ST_RUN   = 3'd4,
    ST_POST  = 3'd5,
    ST_TRAIL = 3'd6
  } lane_st_e;

  localparam int unsigned NUM_OVR = 2;
  localparam int unsigned OVR_HS  = 0;
  localparam int unsigned OVR_LP  = 1;
endpackage

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = (load_val_i == '0) ? ONE : load_val_i;
      cnt_en = 1'b1;
    end else if (cnt_q > ONE) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q <= ONE);
endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
  import clk_lane_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hs_req_i,
  input  logic         ana_ready_i,
  input  logic         pwr_down_i,
  input  logic         tmr_done_i,
  input  logic [W-1:0] lpx_i,
  input  logic [W-1:0] prep_i,
  input  logic [W-1:0] zero_i,
  input  logic [W-1:0] post_i,
  input  logic [W-1:0] trail_i,
  output lane_st_e     state_o,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o
);
  lane_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_STOP: if (hs_req_i && ana_ready_i) begin
        st_d = ST_LPX;  tmr_load_o = 1'b1; tmr_val_o = lpx_i;
      end
      ST_LPX: if (tmr_done_i) begin
        st_d = ST_PREP; tmr_load_o = 1'b1; tmr_val_o = prep_i;
      end
      ST_PREP: if (tmr_done_i) begin
        st_d = ST_ZERO; tmr_load_o = 1'b1; tmr_val_o = zero_i;
      end
      ST_ZERO: if (tmr_done_i) st_d = ST_RUN;
      ST_RUN: if (!hs_req_i) begin
        st_d = ST_POST; tmr_load_o = 1'b1; tmr_val_o = post_i;
      end
      ST_POST: if (tmr_done_i) begin
        st_d = ST_TRAIL; tmr_load_o = 1'b1; tmr_val_o = trail_i;
      end
      ST_TRAIL: if (tmr_done_i) st_d = ST_STOP;
      default: st_d = ST_STOP;
    endcase
    if (pwr_down_i) begin
      st_d       = ST_STOP;
      tmr_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_STOP;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/clk_lane_ready.sv
module clk_lane_ready #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         running_i,
  input  logic [W-1:0] pre_i,
  output logic         ready_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] pre_len;
  logic [W-1:0] run_q, run_d;
  logic         run_en;

  assign pre_len = (pre_i == '0) ? ONE : pre_i;

  always_comb begin
    run_d  = run_q;
    run_en = 1'b0;
    if (!running_i) begin
      run_d  = '0;
      run_en = (run_q != '0);
    end else if (run_q < pre_len) begin
      run_d  = run_q + ONE;
      run_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign ready_o = running_i && (run_q >= pre_len);
endmodule

// File: rtl/clk_lane_ovr.sv
module clk_lane_ovr #(
  parameter int unsigned N = 2
) (
  input  logic         pwr_down_i,
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] val_i,
  input  logic [N-1:0] fsm_i,
  output logic [N-1:0] out_o
);
  for (genvar g = 0; g < N; g++) begin : g_mux
    assign out_o[g] = !pwr_down_i && (sel_i[g] ? val_i[g] : fsm_i[g]);
  end
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int unsigned FW  = 8,
  parameter int unsigned PTW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hs_req_i,
  input  logic          ana_ready_i,
  input  logic          pwr_down_i,
  input  logic [4*FW-1:0] clk_tim_i,
  input  logic [PTW-1:0] pre_tim_i,
  input  logic [FW-1:0] tlpx_i,
  input  logic          hs_sel_i,
  input  logic          hs_val_i,
  input  logic          lp_sel_i,
  input  logic          lp_val_i,
  output logic          tx_lp_en_o,
  output logic          tx_hs_en_o,
  output logic [1:0]    lp_line_o,
  output logic          clk_run_o,
  output logic          clk_ready_o,
  output logic [3:0]    status_o
);
  localparam int unsigned TRAIL_LO = 0;
  localparam int unsigned POST_LO  = FW;
  localparam int unsigned ZERO_LO  = 2 * FW;
  localparam int unsigned PREP_LO  = 3 * FW;

  logic [FW-1:0] f_prep, f_zero, f_post, f_trail, f_pre;
  assign f_prep  = clk_tim_i[PREP_LO  +: FW];
  assign f_zero  = clk_tim_i[ZERO_LO  +: FW];
  assign f_post  = clk_tim_i[POST_LO  +: FW];
  assign f_trail = clk_tim_i[TRAIL_LO +: FW];
  assign f_pre   = pre_tim_i[FW-1:0];

  logic unused_pre_hi;
  assign unused_pre_hi = ^pre_tim_i[PTW-1:FW];

  lane_st_e      state;
  logic          tmr_load, tmr_done;
  logic [FW-1:0] tmr_val;
  logic          ready_raw;

  clk_lane_timer #(.W(FW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .done_o(tmr_done)
  );

  clk_lane_fsm #(.W(FW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_req_i(hs_req_i),
    .ana_ready_i(ana_ready_i), .pwr_down_i(pwr_down_i),
    .tmr_done_i(tmr_done), .lpx_i(tlpx_i), .prep_i(f_prep),
    .zero_i(f_zero), .post_i(f_post), .trail_i(f_trail),
    .state_o(state), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val)
  );

  clk_lane_ready #(.W(FW)) u_rdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .running_i(state == ST_RUN),
    .pre_i(f_pre), .ready_o(ready_raw)
  );

  logic sm_hs, sm_lp, in_stop;
  always_comb begin
    sm_hs     = 1'b0;
    sm_lp     = 1'b0;
    lp_line_o = 2'b00;
    unique case (state)
      ST_STOP:  begin sm_lp = 1'b1; lp_line_o = 2'b11; end
      ST_LPX:   begin sm_lp = 1'b1; lp_line_o = 2'b01; end
      ST_PREP:  begin sm_lp = 1'b1; lp_line_o = 2'b00; end
      ST_ZERO, ST_RUN, ST_POST, ST_TRAIL: sm_hs = 1'b1;
      default:  begin sm_lp = 1'b1; lp_line_o = 2'b11; end
    endcase
  end
  assign in_stop = (state == ST_STOP);

  logic [NUM_OVR-1:0] ovr_sel, ovr_val, ovr_fsm, ovr_out;
  assign ovr_sel[OVR_HS] = hs_sel_i;
  assign ovr_sel[OVR_LP] = lp_sel_i;
  assign ovr_val[OVR_HS] = hs_val_i;
  assign ovr_val[OVR_LP] = lp_val_i;
  assign ovr_fsm[OVR_HS] = sm_hs;
  assign ovr_fsm[OVR_LP] = sm_lp;

  clk_lane_ovr #(.N(NUM_OVR)) u_ovr (
    .pwr_down_i(pwr_down_i), .sel_i(ovr_sel), .val_i(ovr_val),
    .fsm_i(ovr_fsm), .out_o(ovr_out)
  );

  assign tx_hs_en_o  = ovr_out[OVR_HS];
  assign tx_lp_en_o  = ovr_out[OVR_LP];
  assign clk_run_o   = !pwr_down_i && ((state == ST_RUN) || (state == ST_POST));
  assign clk_ready_o = !pwr_down_i && ready_raw;
  assign status_o    = {ana_ready_i, in_stop, 1'b0, sm_hs};
endmodule

// File: rtl/clk_lane_seq_chk.sv
module clk_lane_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hs_req_i,
  input logic       ana_ready_i,
  input logic       pwr_down_i,
  input logic       hs_sel_i,
  input logic       lp_sel_i,
  input logic       tx_lp_en_o,
  input logic       tx_hs_en_o,
  input logic [1:0] lp_line_o,
  input logic       clk_run_o,
  input logic       clk_ready_o,
  input logic [3:0] status_o
);
  // R2: state machine never enables both drivers
  p_enables_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_sel_i && !lp_sel_i) |-> !(tx_lp_en_o && tx_hs_en_o));

  // R2: a sampled request in stop starts LP-01 next cycle
  p_stop_to_lpx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && hs_req_i && ana_ready_i && !pwr_down_i)
      |=> (lp_line_o == 2'b01 || pwr_down_i));

  // R2: clock starts only from HS-0
  p_run_after_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_run_o) |-> $past(status_o[0]));

  // R5: ready only while the clock runs
  p_ready_running_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ready_o |-> clk_run_o);

  // R6: clock stops into HS-0 trail, not straight to LP
  p_trail_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_run_o) && !pwr_down_i && !$past(pwr_down_i)) |-> status_o[0]);

  // R8: no entry without analog ready
  p_hold_no_ana_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && !ana_ready_i) |=> status_o[2]);

  // R9: stop status implies LP-11
  p_stop_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> (lp_line_o == 2'b11));

  // R11: power-down idles the lane
  p_pwr_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> (!tx_lp_en_o && !tx_hs_en_o && !clk_run_o && !clk_ready_o));

  // R11: back in stop one edge after power-down
  p_pwr_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> status_o[2]);
endmodule

bind clk_lane_seq clk_lane_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hs_req_i(hs_req_i),
  .ana_ready_i(ana_ready_i), .pwr_down_i(pwr_down_i),
  .hs_sel_i(hs_sel_i), .lp_sel_i(lp_sel_i),
  .tx_lp_en_o(tx_lp_en_o), .tx_hs_en_o(tx_hs_en_o),
  .lp_line_o(lp_line_o), .clk_run_o(clk_run_o),
  .clk_ready_o(clk_ready_o), .status_o(status_o)
);

// File: tb/sim_clk_lane_seq.sv
`timescale 1ns/1ps
module sim_clk_lane_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        hs_req_i, ana_ready_i, pwr_down_i;
  logic [31:0] clk_tim_i, pre_tim_i;
  logic [7:0]  tlpx_i;
  logic        hs_sel_i, hs_val_i, lp_sel_i, lp_val_i;
  logic        tx_lp_en_o, tx_hs_en_o, clk_run_o, clk_ready_o;
  logic [1:0]  lp_line_o;
  logic [3:0]  status_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam int PH_STOP = 0, PH_LPX = 1, PH_PREP = 2, PH_HS0 = 3, PH_CLK = 4, PH_X = 5;

  always #10 clk_i = ~clk_i;

  clk_lane_seq u0 (.*);

  function automatic int plen(input logic [7:0] f);
    return (f == 8'd0) ? 1 : int'(f);
  endfunction

  function automatic int phase();
    if (tx_lp_en_o && lp_line_o == 2'b11) return PH_STOP;
    if (tx_lp_en_o && lp_line_o == 2'b01) return PH_LPX;
    if (tx_lp_en_o && lp_line_o == 2'b00) return PH_PREP;
    if (tx_hs_en_o && !clk_run_o)         return PH_HS0;
    if (clk_run_o)                        return PH_CLK;
    return PH_X;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input int kind, output int n);
    n = 0;
    while (phase() == kind && n < 600) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic burst(input logic [7:0] lpx, input logic [7:0] pr, input logic [7:0] ze,
                       input logic [7:0] po, input logic [7:0] tr, input logic [31:0] pre,
                       input int hold, input bit rereq);
    int n;
    tlpx_i    = lpx;
    clk_tim_i = {pr, ze, po, tr};
    pre_tim_i = pre;
    hs_req_i  = 1'b1;
    @(negedge clk_i);
    meas(PH_LPX, n);  chk("R2 LP-01 length (R4)", n, plen(lpx));
    meas(PH_PREP, n); chk("R3 prepare bits 31:24 length", n, plen(pr));
    meas(PH_HS0, n);  chk("R3 zero bits 23:16 length", n, plen(ze));
    chk("R9 status while running", int'(status_o), 4'b1001);
    n = 0;
    while (clk_run_o && !clk_ready_o && n < 600) begin n++; @(negedge clk_i); end
    chk("R5 running cycles before ready", n, plen(pre[7:0]));
    repeat (hold) @(negedge clk_i);
    hs_req_i = 1'b0;
    @(negedge clk_i);
    chk("R5 ready low in post", int'(clk_ready_o), 0);
    if (rereq) hs_req_i = 1'b1;
    meas(PH_CLK, n); chk("R6 post bits 15:8 length", n, plen(po));
    meas(PH_HS0, n); chk("R6 trail bits 7:0 length", n, plen(tr));
    if (rereq) begin
      meas(PH_STOP, n); chk("R7 stop cycles before re-entry", n, 1);
      chk("R7 re-entry starts LP-01", phase(), PH_LPX);
      hs_req_i = 1'b0;
      n = 0;
      while (phase() != PH_STOP && n < 2000) begin n++; @(negedge clk_i); end
    end
    chk("R6 returns to stop", phase(), PH_STOP);
    chk("R9 status in stop", int'(status_o), 4'b1100);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_ni = 1'b0; hs_req_i = 1'b0; ana_ready_i = 1'b1; pwr_down_i = 1'b0;
    clk_tim_i = '0; pre_tim_i = '0; tlpx_i = 8'd1;
    hs_sel_i = 1'b0; hs_val_i = 1'b0; lp_sel_i = 1'b0; lp_val_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 tx_lp_en", int'(tx_lp_en_o), 1);
    chk("R1 tx_hs_en", int'(tx_hs_en_o), 0);
    chk("R1 lp_line", int'(lp_line_o), 3);
    chk("R1 clk_run", int'(clk_run_o), 0);
    chk("R1 clk_ready", int'(clk_ready_o), 0);

    // R3 distinct field values, R4 all-zero fields
    burst(8'd2, 8'd3, 8'd5, 8'd7, 8'd2, 32'h0000_0004, 3, 1'b0);
    burst(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 32'h0000_0000, 0, 1'b0);
    // R5 upper pre bits ignored
    burst(8'd1, 8'd2, 8'd1, 8'd3, 8'd4, 32'hFFFF_FF03, 2, 1'b0);
    // R7 request during exit
    burst(8'd3, 8'd1, 8'd2, 8'd4, 8'd3, 32'h0000_0002, 1, 1'b1);

    // R8 no entry without analog ready
    ana_ready_i = 1'b0; hs_req_i = 1'b1;
    repeat (8) @(negedge clk_i);
    chk("R8 stays in stop", phase(), PH_STOP);
    chk("R8 status analog bit low", int'(status_o), 4'b0100);
    ana_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R8 entry once ready", phase(), PH_LPX);
    hs_req_i = 1'b0;
    n = 0;
    while (phase() != PH_STOP && n < 200) begin n++; @(negedge clk_i); end

    // R10 overrides
    hs_sel_i = 1'b1; hs_val_i = 1'b1; lp_sel_i = 1'b1; lp_val_i = 1'b0;
    #1;
    chk("R10 hs override", int'(tx_hs_en_o), 1);
    chk("R10 lp override", int'(tx_lp_en_o), 0);
    chk("R10 status unaffected", int'(status_o), 4'b1100);
    hs_sel_i = 1'b0; lp_sel_i = 1'b0;
    #1;
    chk("R10 release hs", int'(tx_hs_en_o), 0);
    chk("R10 release lp", int'(tx_lp_en_o), 1);
    @(negedge clk_i);

    // R11 power-down while running
    tlpx_i = 8'd1; clk_tim_i = 32'h0101_0101; pre_tim_i = 32'd1;
    hs_req_i = 1'b1;
    n = 0;
    while (!clk_run_o && n < 200) begin n++; @(negedge clk_i); end
    hs_sel_i = 1'b1; hs_val_i = 1'b1;
    pwr_down_i = 1'b1;
    #1;
    chk("R11 hs enable low despite select", int'(tx_hs_en_o), 0);
    chk("R11 lp enable low", int'(tx_lp_en_o), 0);
    chk("R11 clock stopped", int'(clk_run_o), 0);
    hs_sel_i = 1'b0; hs_val_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R11 held in stop", int'(status_o), 4'b1100);
    pwr_down_i = 1'b0; hs_req_i = 1'b0;
    #1;
    chk("R11 stop after release", phase(), PH_STOP);
    @(negedge clk_i);

    // random bursts
    for (int i = 0; i < 24; i++) begin
      burst(8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6),
            8'($urandom % 6), {24'($urandom), 8'($urandom % 7)},
            int'($urandom % 4), 1'($urandom % 2));
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule